// File: doc/BRIEF.md
# Electronic Shutter Speed Controller

This block decides how long a CCD sensor integrates charge. It reads the exposure mode and a 9-bit load value from one of two sources. The first is a set of static pins: two mode pins and a 3-bit speed code. The second is a three-wire serial word made of strobe, clock and data. The chosen setting is held in a pending register. It becomes the working setting only when a field-start strobe arrives.

From the working setting the block raises discharge enables for the substrate pulse generator. In the two line-based modes (flickerless and high-speed), the leading lines of each field are discharged and exposure runs over the remaining lines. In low-speed mode, one discharge is issued at a field boundary every 2·(0x1FF − L) fields. In shutter-off mode, no discharge is ever requested.

The three serial wires are slow asynchronous inputs. They are synchronized to the system clock before any edge is detected. The line-start and field-start strobes are single-cycle pulses that are already synchronous to that clock.

Top module: `shutter_ctl`

## Requirements
- R1: After reset, exp_mode is 3 (off), exp_load is 0x1FF, and dump_line and dump_field are low.
- R2: With ser_sel low, the pending mode is {mode_pin[1], mode_pin[0]}. The encoding is 0 = flickerless, 1 = high-speed, 2 = low-speed, 3 = off.
- R3: With ser_sel low, the pending load depends on the pending mode:
  - high-speed: speed_pin codes 0..7 give 0x0C8, 0x0CA, 0x0CE, 0x0D6, 0x0E6, 0x105, 0x143 and 0x149;
  - low-speed: the load is 0x1FE minus the code;
  - off: the load is 0x1FF.
- R4: The serial word is 12 bits, sent in this order: mode bit 1, mode bit 2, a dummy bit, then load bits d0 (LSB) to d8. A bit is taken on each rising edge of ser_clk. The word becomes pending on a rising edge of ser_stb.
- R5: With ser_sel high, the mode and load come from the last strobed word. mode_pin and speed_pin have no effect.
- R6: exp_mode and exp_load change only on a cycle that carries field_start, where they take the pending values. A strobe or pin change between field starts leaves them unchanged.
- R7: In flickerless or high-speed mode, dump_line rises one cycle after a line_start whose line index is below 0x1FF − L. The line that coincides with field_start has index 0.
- R8: In low-speed mode with N = 2·(0x1FF − L), dump_field pulses one cycle after a field_start in either of two cases: the setting just changed, or N−1 quiet field starts have passed since the last pulse.
- R9: Low-speed mode with load 0x1FF never raises dump_field. It is treated as off.
- R10: In off mode neither dump output rises.
- R11: Flickerless mode always uses load 0x149, whatever the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_sel | input | 1 | 0 selects the pin setting, 1 selects the serial word |
| mode_pin | input | 2 | Parallel mode pins |
| speed_pin | input | 3 | Parallel speed code |
| ser_stb | input | 1 | Serial strobe; a rising edge commits the word |
| ser_clk | input | 1 | Serial clock; a rising edge shifts one bit |
| ser_dat | input | 1 | Serial data |
| line_start | input | 1 | One-cycle pulse at each line start |
| field_start | input | 1 | One-cycle pulse at each field start, issued together with that field's first line_start |
| exp_mode | output | 2 | Working exposure mode |
| exp_load | output | 9 | Working load value |
| dump_line | output | 1 | Per-line discharge enable |
| dump_field | output | 1 | Per-field discharge enable |

## Verification
The checker watches every cycle for the following:
- each dump pulse follows its strobe by exactly one cycle;
- the working setting moves only on a field start;
- off mode and low-speed with load 0x1FF stay silent;
- flickerless always carries load 0x149.

Some behaviour can only be shown by the bench scenarios. A scoreboard predicts the exact line indices and field numbers that must be discharged. It does so for parallel codes, serial words, pin changes made while in serial mode, and setting changes in the middle of a low-speed cycle. Those scenarios are the only evidence for the serial bit order, the speed-code table and the length of the low-speed cycle.

// File: rtl/shutter_ctl.sv
module shutter_ctl #(
  parameter int LW = 9,
  parameter int WW = 12,
  parameter int CW = 10,
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_sel,
  input  logic [1:0]    mode_pin,
  input  logic [2:0]    speed_pin,
  input  logic          ser_stb,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          line_start,
  input  logic          field_start,
  output logic [1:0]    exp_mode,
  output logic [LW-1:0] exp_load,
  output logic          dump_line,
  output logic          dump_field
);
  localparam logic [1:0] M_FLK = 2'd0, M_HI = 2'd1, M_LO = 2'd2, M_OFF = 2'd3;
  localparam logic [LW-1:0] LMAX = '1;
  localparam logic [LW-1:0] FLK_LOAD = LW'(329);
  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0] sc_q, ss_q;
  logic [1:0] sd_q;
  logic [WW-1:0] shreg, word;
  logic [LW-1:0] ser_load, tab_load, pend_load, use_load, limit;
  logic [1:0] ser_mode, pend_mode, use_mode;
  logic [CW-1:0] lcnt, line_idx;
  logic [FW-1:0] fcnt, nfld;
  logic clk_rise, stb_rise, changed, line_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q <= '0;
      ss_q <= '0;
      sd_q <= '0;
    end else begin
      sc_q <= {sc_q[1:0], ser_clk};
      ss_q <= {ss_q[1:0], ser_stb};
      sd_q <= {sd_q[0], ser_dat};
    end
  end

  assign clk_rise = sc_q[1] & ~sc_q[2];
  assign stb_rise = ss_q[1] & ~ss_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      word  <= '1;
    end else begin
      if (clk_rise) shreg <= {shreg[WW-2:0], sd_q[1]};
      if (stb_rise) word <= shreg;
    end
  end

  assign ser_mode = word[WW-1 -: 2];

  always_comb begin
    for (int i = 0; i < LW; i++) ser_load[i] = word[LW-1-i];
  end

  always_comb begin
    case (speed_pin)
      3'd0: tab_load = LW'(9'h0C8);
      3'd1: tab_load = LW'(9'h0CA);
      3'd2: tab_load = LW'(9'h0CE);
      3'd3: tab_load = LW'(9'h0D6);
      3'd4: tab_load = LW'(9'h0E6);
      3'd5: tab_load = LW'(9'h105);
      3'd6: tab_load = LW'(9'h143);
      default: tab_load = LW'(9'h149);
    endcase
  end

  assign pend_mode = ser_sel ? ser_mode : mode_pin;

  always_comb begin
    case (pend_mode)
      M_FLK:   pend_load = FLK_LOAD;
      M_HI:    pend_load = ser_sel ? ser_load : tab_load;
      M_LO:    pend_load = ser_sel ? ser_load : (LMAX - 1'b1 - LW'(speed_pin));
      default: pend_load = ser_sel ? ser_load : LMAX;
    endcase
  end

  assign use_mode  = field_start ? pend_mode : exp_mode;
  assign use_load  = field_start ? pend_load : exp_load;
  assign limit     = LMAX - use_load;
  assign line_idx  = field_start ? '0 : lcnt;
  assign line_mode = (use_mode == M_FLK) || (use_mode == M_HI);
  assign nfld      = FW'({limit, 1'b0});
  assign changed   = (pend_mode != exp_mode) || (pend_load != exp_load);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_mode   <= M_OFF;
      exp_load   <= LMAX;
      lcnt       <= '0;
      fcnt       <= '0;
      dump_line  <= 1'b0;
      dump_field <= 1'b0;
    end else begin
      dump_line  <= line_start && line_mode && (line_idx < CW'(limit));
      dump_field <= 1'b0;
      if (line_start)
        lcnt <= (line_idx == CMAX) ? CMAX : line_idx + 1'b1;
      if (field_start) begin
        exp_mode <= pend_mode;
        exp_load <= pend_load;
        if (pend_mode == M_LO && pend_load != LMAX) begin
          if (fcnt == '0 || changed) begin
            dump_field <= 1'b1;
            fcnt       <= nfld - 1'b1;
          end else begin
            fcnt <= fcnt - 1'b1;
          end
        end else begin
          fcnt <= '0;
        end
      end
    end
  end
endmodule

module shutter_ctl_chk #(
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          field_start,
  input logic [1:0]    exp_mode,
  input logic [LW-1:0] exp_load,
  input logic          dump_line,
  input logic          dump_field
);
  // R7
  line_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_line |-> $past(line_start) && (exp_mode == 2'd0 || exp_mode == 2'd1));
  // R8
  field_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_field |-> $past(field_start) && exp_mode == 2'd2);
  // R6
  hold_between_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(field_start) |-> $stable(exp_mode) && $stable(exp_load));
  // R9
  low_max_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_mode == 2'd2 && exp_load == '1) |-> !dump_field);
  // R10
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_mode == 2'd3 |-> !dump_line && !dump_field);
  // R11
  flicker_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_mode == 2'd0 |-> exp_load == LW'(329));
endmodule

bind shutter_ctl shutter_ctl_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
  .exp_mode(exp_mode), .exp_load(exp_load), .dump_line(dump_line), .dump_field(dump_field)
);

// File: tb/shutter_ctl_test.sv
module shutter_ctl_test;
  logic clk = 0, rst_n = 0;
  logic ser_sel = 0, ser_stb = 0, ser_clk = 0, ser_dat = 0;
  logic line_start = 0, field_start = 0;
  logic [1:0] mode_pin = 2'd3;
  logic [2:0] speed_pin = 3'd0;
  logic [1:0] exp_mode;
  logic [8:0] exp_load;
  logic dump_line, dump_field;

  int total = 0, bad = 0, cycles = 0;
  int cur_line = 0, cur_field = 0;
  int q[$];
  logic [1:0] app_m = 2'd3, ser_m = 2'd3;
  logic [8:0] app_l = 9'h1FF, ser_l = 9'h1FF;
  int fcnt_m = 0;
  bit done = 0;

  shutter_ctl uut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .mode_pin(mode_pin), .speed_pin(speed_pin),
    .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_dat(ser_dat), .line_start(line_start),
    .field_start(field_start), .exp_mode(exp_mode), .exp_load(exp_load),
    .dump_line(dump_line), .dump_field(dump_field)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each discharge event
  task automatic pop_cmp(input int item, input string req);
    if (q.size() == 0) check(0, req, item, -1);
    else begin
      int e = q.pop_front();
      check(e == item, req, item, e);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cycles++;
    if (dump_field) pop_cmp(100000 + cur_field, "R8 field dump");
    if (dump_line) pop_cmp(cur_line, "R7 line dump");
  end

  function automatic void pending(output logic [1:0] m, output logic [8:0] l);
    logic [8:0] tab [8] = '{9'h0C8, 9'h0CA, 9'h0CE, 9'h0D6, 9'h0E6, 9'h105, 9'h143, 9'h149};
    m = ser_sel ? ser_m : mode_pin;
    case (m)
      2'd0: l = 9'h149;
      2'd1: l = ser_sel ? ser_l : tab[speed_pin];
      2'd2: l = ser_sel ? ser_l : 9'h1FE - 9'(speed_pin);
      default: l = ser_sel ? ser_l : 9'h1FF;
    endcase
  endfunction

  // driver: predicts one field, pushes expectations, then drives it
  task automatic run_field();
    logic [1:0] m; logic [8:0] l; bit chg; int lim;
    pending(m, l);
    chg = (m != app_m) || (l != app_l);
    app_m = m; app_l = l;
    cur_field++;
    if (m == 2'd2 && l != 9'h1FF) begin
      if (fcnt_m == 0 || chg) begin
        q.push_back(100000 + cur_field);
        fcnt_m = 2 * (511 - l) - 1;
      end else fcnt_m--;
    end else fcnt_m = 0;
    lim = 511 - l;
    if (m <= 2'd1) for (int i = 0; i < 312; i++) if (i < lim) q.push_back(i);
    for (int i = 0; i < 312; i++) begin
      @(negedge clk);
      cur_line = i; line_start = 1; field_start = (i == 0);
      @(negedge clk);
      line_start = 0; field_start = 0;
    end
    @(negedge clk);
    check(q.size() == 0, "R7/R8 all predicted dumps seen", q.size(), 0);
    check(exp_mode == app_m, "R6 mode applied at field", exp_mode, app_m);
    check(exp_load == app_l, "R6 load applied at field", exp_load, app_l);
  endtask

  task automatic ser_edge(input bit v);
    ser_clk = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [1:0] m, input logic [8:0] l);
    logic [11:0] bits;
    bits = {m, 1'b0, l[0], l[1], l[2], l[3], l[4], l[5], l[6], l[7], l[8]};
    for (int i = 11; i >= 0; i--) begin
      ser_dat = bits[i];
      ser_edge(0);
      ser_edge(1);
    end
    ser_edge(0);
    ser_stb = 1; repeat (3) @(negedge clk);
    ser_stb = 0; repeat (3) @(negedge clk);
    ser_m = m; ser_l = l;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(exp_mode == 2'd3, "R1 reset mode", exp_mode, 3);
    check(exp_load == 9'h1FF, "R1 reset load", exp_load, 9'h1FF);
    check(!dump_line && !dump_field, "R1 reset dumps", {dump_line, dump_field}, 0);
    // R10 off field
    run_field();
    // R2 R3 parallel high-speed, fastest code
    mode_pin = 2'd1; speed_pin = 3'd0;
    repeat (4) @(negedge clk);
    check(exp_mode == 2'd3, "R6 pins not applied before field", exp_mode, 3);
    run_field();
    speed_pin = 3'd6; run_field();
    // R11 flickerless
    mode_pin = 2'd0; run_field();
    // R3 low-speed code 0 -> 2 fields, then code 1 -> 4 fields
    mode_pin = 2'd2; speed_pin = 3'd0;
    repeat (3) run_field();
    speed_pin = 3'd1;
    repeat (5) run_field();
    // R4 R5 serial high-speed word, pins say off
    mode_pin = 2'd3; ser_sel = 1;
    send_word(2'd1, 9'h0D6);
    check(exp_mode == 2'd2, "R6 strobe not applied before field", exp_mode, 2);
    run_field();
    check(exp_load == 9'h0D6, "R4 serial load bit order", exp_load, 9'h0D6);
    // R5 pins changed while serial: no effect
    mode_pin = 2'd2; speed_pin = 3'd3;
    run_field();
    // R8 serial low-speed 0x1FD -> 4 fields
    send_word(2'd2, 9'h1FD);
    repeat (6) run_field();
    // R11 serial flickerless ignores word load
    send_word(2'd0, 9'h0C8);
    run_field();
    check(exp_load == 9'h149, "R11 flickerless load", exp_load, 9'h149);
    // R9 low-speed with 0x1FF
    send_word(2'd2, 9'h1FF);
    repeat (3) run_field();
    // R10 serial off
    send_word(2'd3, 9'h0C8);
    repeat (2) run_field();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=finish", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule